// File: doc/BRIEF.md
# Dual-Channel DAC Command Decoder

This block is the digital front end of a two-channel 10-bit converter. A host sends 16-bit command words over a three-wire serial link made of an active-low select, a shift clock and a data line. The block samples all three lines on its own system clock, puts each frame together, and on the closing edge of select decodes the frame into register operations for channels A and B.

Each channel has two registers. The input register is a staging register that a command can write without changing the output. The DAC register holds the value the converter actually uses. Each channel also has a power state and a shutdown-load selection. One bias-enable flag is shared by both channels.

Commands can:
- write one staging register,
- write a staging register and then refresh both DAC registers,
- write the same data into all four registers,
- copy the staged values into the DAC registers,
- power channels down with a chosen load,
- shut down the bias.

The analog parts of the converter are not modelled here.

Top module: `dual_dac_cmd_dec`

## Requirements
- R1: Frame capture and bit order.
  - A frame is shifted most-significant bit first, one bit per rising edge of `sclk_i` while `cs_n_i` is low.
  - The frame is decoded on the rising edge of `cs_n_i`.
  - Frame layout: bits [15:13] are the 3-bit opcode, bits [12:3] are the 10-bit data field (bit 12 is data bit 9), and bits [2:0] are the tail.
- R2: A frame is discarded with no state change if either of these holds:
  - the number of clock edges received while selected is not exactly 16;
  - the tail bits are not all zero.
- R3: Opcode 001 writes the data into staging register A. Opcode 101 writes it into staging register B. Neither changes a DAC register or a power state.
- R4: Opcode 010 (for A) and opcode 110 (for B) write the data into that channel's staging register. Both DAC registers are then loaded from their staging registers, and both channels wake.
- R5: Opcode 011 writes the data into both staging registers and both DAC registers, and wakes both channels.
- R6: Opcode 100 ignores the data field. It copies each staging register into its own DAC register and wakes both channels.
- R7: Opcode 111 powers down both channels.
  - Data bit 9 is the load selection for A; data bit 8 is the load selection for B.
  - Load encoding: 0 selects the 1 kΩ load, 1 selects the 200 kΩ load.
  - Bias and DAC registers are unchanged.
- R8: With opcode 000, data bits 9..7 hold a sub-opcode.
  - Sub-opcode 001 loads DAC A from staging A and wakes A only.
  - Sub-opcode 101 does the same for channel B.
- R9: With opcode 000, sub-opcode 110 powers down A and sub-opcode 111 powers down B. Data bit 6 is the load selection, with the encoding given in R7.
- R10: With opcode 000, sub-opcode 011 clears the bias enable and powers down both channels. Data bit 6 is the load selection for A and data bit 5 is the load selection for B.
- R11: Every command that loads a DAC register also sets the bias enable.
- R12: After reset:
  - all registers are zero;
  - both channels are powered down with the 1 kΩ load;
  - the bias is enabled.
- R13: With opcode 000, the sub-opcodes 000, 010 and 100 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data in |
| dac_a_o | output | 10 | Channel A DAC register |
| dac_b_o | output | 10 | Channel B DAC register |
| ch_on_o | output | 2 | Channel active flags (bit 0 = A, bit 1 = B) |
| ch_hiz_o | output | 2 | Shutdown load selection (1 = 200 kΩ), bit 0 = A |
| bias_en_o | output | 1 | Bias enable |

## Verification
The bench builds the block with its default parameters: a 10-bit data field, a 3-bit opcode and a 3-bit tail, which give the 16-bit frame, and two synchronizer stages. Each serial clock phase lasts three system clocks, so every edge passes through the synchronizer before the next edge arrives.

With these values the bench can reach:
- frames one bit short and one bit long;
- a nonzero tail;
- every opcode and every defined and undefined sub-opcode;
- distinct, asymmetric data patterns per channel, so that swapped channels or reversed bit order show up at the DAC outputs.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int OP_W  = 3;
  localparam int SUB_W = 3;
  localparam int TAIL_W = 3;
  localparam int N_CH  = 2;

  typedef struct packed {
    logic ld_in;   // write staging register from data field
    logic upd;     // load DAC register (from data if ld_in, else staging)
    logic pd;      // power down
    logic pd_hiz;  // shutdown load: 1 = high impedance
  } ch_ctl_t;
endpackage

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_MAX = FRAME_W + 1;

  logic [SYNC_STAGES-1:0] cs_sync, sclk_sync, sdi_sync;
  logic cs_d, sclk_d;
  logic cs_s, sclk_s, sdi_s;
  logic [CNT_W-1:0] cnt_q;

  assign cs_s   = cs_sync[SYNC_STAGES-1];
  assign sclk_s = sclk_sync[SYNC_STAGES-1];
  assign sdi_s  = sdi_sync[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync   <= '1;
      sclk_sync <= '0;
      sdi_sync  <= '0;
      cs_d      <= 1'b1;
      sclk_d    <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n_i};
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
      sdi_sync  <= {sdi_sync[SYNC_STAGES-2:0], sdi_i};
      cs_d      <= cs_s;
      sclk_d    <= sclk_s;
    end
  end

  logic cs_rise, cs_fall, sclk_rise;
  assign cs_rise   = cs_s & ~cs_d;
  assign cs_fall   = ~cs_s & cs_d;
  assign sclk_rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      frame_o     <= '0;
      frame_vld_o <= 1'b0;
    end else begin
      frame_vld_o <= cs_rise && (cnt_q == CNT_W'(FRAME_W));
      if (cs_fall) begin
        cnt_q <= '0;
      end else if (!cs_s && sclk_rise) begin
        frame_o <= {frame_o[FRAME_W-2:0], sdi_s};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX)); // R2
  AST_VLD_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |-> cs_d); // R1
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W  = 10,
  localparam int FRAME_W = OP_W + DATA_W + TAIL_W
) (
  input  logic                   frame_vld_i,
  input  logic [FRAME_W-1:0]     frame_i,
  output ch_ctl_t [N_CH-1:0]     ctl_o,
  output logic [DATA_W-1:0]      data_o,
  output logic                   bias_on_o,
  output logic                   bias_off_o
);
  logic [OP_W-1:0]   op;
  logic [TAIL_W-1:0] tail;
  logic [SUB_W-1:0]  sub;
  logic ok;

  assign op     = frame_i[FRAME_W-1 -: OP_W];
  assign data_o = frame_i[FRAME_W-OP_W-1 -: DATA_W];
  assign tail   = frame_i[TAIL_W-1:0];
  assign sub    = data_o[DATA_W-1 -: SUB_W];
  assign ok     = frame_vld_i && (tail == '0);

  always_comb begin
    ctl_o      = '0;
    bias_off_o = 1'b0;
    if (ok) begin
      unique case (op)
        3'b001: ctl_o[0].ld_in = 1'b1;
        3'b101: ctl_o[1].ld_in = 1'b1;
        3'b010: begin
          ctl_o[0].ld_in = 1'b1;
          ctl_o[0].upd = 1'b1;
          ctl_o[1].upd = 1'b1;
        end
        3'b110: begin
          ctl_o[1].ld_in = 1'b1;
          ctl_o[0].upd = 1'b1;
          ctl_o[1].upd = 1'b1;
        end
        3'b011: for (int c = 0; c < N_CH; c++) begin
          ctl_o[c].ld_in = 1'b1;
          ctl_o[c].upd   = 1'b1;
        end
        3'b100: for (int c = 0; c < N_CH; c++) ctl_o[c].upd = 1'b1;
        3'b111: for (int c = 0; c < N_CH; c++) begin
          ctl_o[c].pd     = 1'b1;
          ctl_o[c].pd_hiz = data_o[DATA_W-1-c];
        end
        default: begin
          unique case (sub)
            3'b001: ctl_o[0].upd = 1'b1;
            3'b101: ctl_o[1].upd = 1'b1;
            3'b110: begin
              ctl_o[0].pd     = 1'b1;
              ctl_o[0].pd_hiz = data_o[DATA_W-SUB_W-1];
            end
            3'b111: begin
              ctl_o[1].pd     = 1'b1;
              ctl_o[1].pd_hiz = data_o[DATA_W-SUB_W-1];
            end
            3'b011: begin
              bias_off_o = 1'b1;
              for (int c = 0; c < N_CH; c++) begin
                ctl_o[c].pd     = 1'b1;
                ctl_o[c].pd_hiz = data_o[DATA_W-SUB_W-1-c];
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  assign bias_on_o = ctl_o[0].upd | ctl_o[1].upd;

  always_comb begin
    for (int c = 0; c < N_CH; c++)
      AST_NO_PD_WITH_UPD: assert (!(ctl_o[c].pd && ctl_o[c].upd)); // R9
  end
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ch_ctl_t           ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              on_o,
  output logic              hiz_o
);
  logic [DATA_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      dac_o   <= '0;
      on_o    <= 1'b0;
      hiz_o   <= 1'b0;
    end else begin
      if (ctl_i.ld_in) stage_q <= data_i;
      if (ctl_i.upd) begin
        dac_o <= ctl_i.ld_in ? data_i : stage_q;
        on_o  <= 1'b1;
      end else if (ctl_i.pd) begin
        on_o  <= 1'b0;
        hiz_o <= ctl_i.pd_hiz;
      end
    end
  end

  AST_DAC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.upd |=> $stable(dac_o)); // R3
  AST_UPD_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.upd |=> on_o); // R6
  AST_PD_SLEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.pd |=> (!on_o && hiz_o == $past(ctl_i.pd_hiz))); // R7
endmodule

// File: rtl/dual_dac_cmd_dec.sv
module dual_dac_cmd_dec
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o,
  output logic [1:0]        ch_on_o,
  output logic [1:0]        ch_hiz_o,
  output logic              bias_en_o
);
  localparam int FRAME_W = OP_W + DATA_W + TAIL_W;

  logic               frame_vld;
  logic [FRAME_W-1:0] frame;
  ch_ctl_t [N_CH-1:0] ctl;
  logic [DATA_W-1:0]  data;
  logic               bias_on, bias_off;
  logic [DATA_W-1:0]  dac [N_CH];

  dac_serial_rx #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni, .cs_n_i, .sclk_i, .sdi_i,
    .frame_vld_o(frame_vld), .frame_o(frame)
  );

  dac_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .frame_vld_i(frame_vld), .frame_i(frame), .ctl_o(ctl),
    .data_o(data), .bias_on_o(bias_on), .bias_off_o(bias_off)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dac_chan_regs #(.DATA_W(DATA_W)) u_ch (
      .clk_i, .rst_ni, .ctl_i(ctl[c]), .data_i(data),
      .dac_o(dac[c]), .on_o(ch_on_o[c]), .hiz_o(ch_hiz_o[c])
    );
  end

  assign dac_a_o = dac[0];
  assign dac_b_o = dac[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bias_en_o <= 1'b1;
    else if (bias_on)  bias_en_o <= 1'b1;
    else if (bias_off) bias_en_o <= 1'b0;
  end

  AST_BIAS_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bias_on |=> bias_en_o); // R11
  AST_BIAS_SHUTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bias_off |=> (!bias_en_o && ch_on_o == 2'b00)); // R10
  AST_ON_NEEDS_BIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ch_on_o[0]) |-> bias_en_o); // R11
endmodule

// File: tb/sim_dual_dac_cmd_dec.sv
module sim_dual_dac_cmd_dec;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [9:0] dac_a, dac_b;
  logic [1:0] on, hiz;
  logic bias;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_dac_cmd_dec u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_a_o(dac_a), .dac_b_o(dac_b), .ch_on_o(on), .ch_hiz_o(hiz),
    .bias_en_o(bias)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req, int ea, int eb, int eon, int ehiz, int ebias);
    chk(req, "dac_a", int'(dac_a), ea);
    chk(req, "dac_b", int'(dac_b), eb);
    chk(req, "ch_on", int'(on), eon);
    chk(req, "ch_hiz", int'(hiz), ehiz);
    chk(req, "bias", int'(bias), ebias);
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [31:0] bits, int nbits);
    wait_clk(1);
    cs_n = 1'b0;
    wait_clk(3);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_clk(3);
      sclk = 1'b1;
      wait_clk(3);
      sclk = 1'b0;
    end
    wait_clk(3);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  function automatic logic [31:0] frm(logic [2:0] op, logic [9:0] d, logic [2:0] t);
    return {16'h0, op, d, t};
  endfunction

  function automatic logic [31:0] subf(logic [2:0] sub, logic m1, logic m0);
    return frm(3'b000, {sub, m1, m0, 5'b0}, 3'b000);
  endfunction

  task automatic t_reset();
    chk_all("R12", 0, 0, 0, 0, 1);
  endtask

  task automatic t_stage_and_copy();
    send(frm(3'b001, 10'h155, 3'b000), 16);
    chk_all("R3", 0, 0, 0, 0, 1);
    send(frm(3'b100, 10'h3FF, 3'b000), 16);
    chk_all("R6", 'h155, 0, 3, 0, 1);
  endtask

  task automatic t_single_update();
    send(frm(3'b101, 10'h2AA, 3'b000), 16);
    chk_all("R3", 'h155, 0, 3, 0, 1);
    send(subf(3'b101, 1'b0, 1'b0), 16);
    chk_all("R8", 'h155, 'h2AA, 3, 0, 1);
  endtask

  task automatic t_load_update_all();
    send(frm(3'b010, 10'h0F0, 3'b000), 16);
    chk_all("R4", 'h0F0, 'h2AA, 3, 0, 1);
    send(frm(3'b110, 10'h3FF, 3'b000), 16);
    chk_all("R4", 'h0F0, 'h3FF, 3, 0, 1);
  endtask

  task automatic t_pd_both();
    send(frm(3'b111, 10'b10_0000_0000, 3'b000), 16);
    chk_all("R7", 'h0F0, 'h3FF, 0, 1, 1);
    send(subf(3'b001, 1'b0, 1'b0), 16);
    chk_all("R8", 'h0F0, 'h3FF, 1, 1, 1);
  endtask

  task automatic t_pd_single();
    send(subf(3'b111, 1'b1, 1'b0), 16);
    chk_all("R9", 'h0F0, 'h3FF, 1, 3, 1);
    send(subf(3'b110, 1'b0, 1'b0), 16);
    chk_all("R9", 'h0F0, 'h3FF, 0, 2, 1);
  endtask

  task automatic t_full_pd();
    send(subf(3'b011, 1'b0, 1'b1), 16);
    chk_all("R10", 'h0F0, 'h3FF, 0, 2, 0);
    send(frm(3'b011, 10'h001, 3'b000), 16);
    chk_all("R5", 1, 1, 3, 2, 1);
    chk("R11", "bias after load", int'(bias), 1);
    chk("R1", "msb-first dac_a", int'(dac_a), 1);
  endtask

  task automatic t_bad_frames();
    send(frm(3'b011, 10'h3C3, 3'b001), 16);
    chk_all("R2", 1, 1, 3, 2, 1);
    send(frm(3'b011, 10'h3C3, 3'b000) >> 1, 15);
    chk_all("R2", 1, 1, 3, 2, 1);
    send({frm(3'b011, 10'h3C3, 3'b000)[15:0], 1'b0}, 17);
    chk_all("R2", 1, 1, 3, 2, 1);
  endtask

  task automatic t_undefined_sub();
    send(subf(3'b000, 1'b1, 1'b1), 16);
    send(subf(3'b010, 1'b1, 1'b1), 16);
    send(subf(3'b100, 1'b1, 1'b1), 16);
    chk_all("R13", 1, 1, 3, 2, 1);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(3);
    t_reset();
    t_stage_and_copy();
    t_single_update();
    t_load_update_all();
    t_pd_both();
    t_pd_single();
    t_full_pd();
    t_bad_frames();
    t_undefined_sub();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule